// File: doc/BRIEF.md
# Half-Bridge Complementary Pulse Generator with Fixed Deadtime

The block drives the two gate enables of a half-bridge. A free-running period counter acts as a digital sawtooth. Each period holds four windows in a fixed order: low-side on, a dead gap, high-side on, and a second dead gap. Two period lengths are available: a short one for lamp ignition and a longer one for steady running. A trim code shortens the high-side window and gives the freed cycles to the low-side window. The period length and the two dead gaps do not change with the trim code.

The high-side on-time starts at half the period minus the deadtime and falls by one cycle per code step. It never drops below a tenth of the period, rounded up. A separate deadtime counter counts cycles in which both enables are low. It gates every rising edge, so the gap between the two enables can never be shorter than the deadtime, including after an abrupt stop and restart.

Period select and trim code are captured only at a period boundary, or while the block is stopped. A change therefore never cuts a pulse short. Deasserting run or asserting force-off drops both enables at the next clock edge and restarts the sawtooth, and the next period again begins with the low side.

Top module: `hb_pulse_gen`

## Requirements
- R1: `ho_o` and `lo_o` are never high in the same cycle.
- R2: Each time either enable falls, both stay low for at least DT_CYCLES cycles (default 4) before either one rises. In steady operation each dead gap is exactly DT_CYCLES cycles and does not depend on the selected period.
- R3: With `period_sel_i` = 0 (ignition) the time from one `lo_o` rise to the next is IGN_PERIOD cycles (default 60). With `period_sel_i` = 1 (run) it is RUN_PERIOD cycles (default 100), for every trim code.
- R4: Within a period, `lo_o` is high first, then `ho_o`. The `ho_o` on-time is floor(P/2) − DT_CYCLES − code, where P is the period and code is `duty_code_i`. The `lo_o` on-time is P − 2·DT_CYCLES minus the `ho_o` on-time, so code 0 gives the largest high-side window.
- R5: The `ho_o` on-time never falls below ceil(P/10) cycles (6 for ignition, 10 for run). Every larger code gives that floor.
- R6: After reset, and after every restart (`run_i` high and `force_off_i` low again), the first enable to rise is `lo_o`.
- R7: If `force_off_i` is high or `run_i` is low at a clock edge, both enables are low from that edge on, and the sawtooth restarts from zero.
- R8: A new `period_sel_i` or `duty_code_i` value takes effect only from the next period boundary. The period in progress completes with the values captured at its start.
- R9: While `rst_ni` is low, both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables switching while high |
| force_off_i | input | 1 | Forces both enables low and restarts the sawtooth |
| period_sel_i | input | 1 | 0: ignition period, 1: run period |
| duty_code_i | input | DUTY_W | High-side on-time reduction in cycles |
| ho_o | output | 1 | High-side gate enable |
| lo_o | output | 1 | Low-side gate enable |

## Verification
Code 0 in both modes is tried for the widest high-side window. Codes just below, at and far above the clamp point separate plain linear trimming from the floor. A trim change made right at a period start shows whether capture waits for the boundary: the following period must keep the old widths. Seeded random mode and code pairs check the pulse widths and period length against bench formulas, so a wrong constant in either mode is exposed. Stops asserted during high-side on-time and during low-side on-time exercise the immediate shutdown and the low-side-first restart.

// File: rtl/hb_pulse_pkg.sv
package hb_pulse_pkg;
  localparam int unsigned CNT_W = 10;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {
    MODE_IGN = 1'b0,
    MODE_RUN = 1'b1
  } mode_e;

  // compare points of one period: lo on [0,lo_end), ho on [ho_start,ho_end)
  typedef struct packed {
    cnt_t last;
    cnt_t lo_end;
    cnt_t ho_start;
    cnt_t ho_end;
  } win_t;
endpackage

// File: rtl/hb_win_calc.sv
module hb_win_calc
  import hb_pulse_pkg::*;
#(
  parameter int unsigned IGN_PERIOD = 60,
  parameter int unsigned RUN_PERIOD = 100,
  parameter int unsigned DT_CYCLES  = 4,
  parameter int unsigned DUTY_W     = 6,
  parameter int unsigned FLOOR_DIV  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic [DUTY_W-1:0] code_i,
  output win_t              win_o
);
  localparam int unsigned NMODE = 2;

  function automatic win_t mk_win(int unsigned n, int unsigned code);
    int unsigned ho_max, ho_min, ho, lo;
    win_t w;
    ho_max = n / 2 - DT_CYCLES;
    ho_min = (n + FLOOR_DIV - 1) / FLOOR_DIV;
    ho     = (code >= ho_max - ho_min) ? ho_min : ho_max - code;
    lo     = n - 2 * DT_CYCLES - ho;
    w.last     = cnt_t'(n - 1);
    w.lo_end   = cnt_t'(lo);
    w.ho_start = cnt_t'(lo + DT_CYCLES);
    w.ho_end   = cnt_t'(n - DT_CYCLES);
    return w;
  endfunction

  localparam win_t RST_WIN = mk_win(IGN_PERIOD, 0);

  win_t mode_win [NMODE];

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam int unsigned N = (m == int'(MODE_RUN)) ? RUN_PERIOD : IGN_PERIOD;
    always_comb mode_win[m] = mk_win(N, 32'(code_i));
  end

  win_t win_d, win_q;
  assign win_d = (mode_e'(sel_i) == MODE_RUN) ? mode_win[1] : mode_win[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= RST_WIN;
    else if (load_i) win_q <= win_d;
  end

  assign win_o = win_q;
endmodule

// File: rtl/hb_ramp.sv
module hb_ramp
  import hb_pulse_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  cnt_t last_i,
  output cnt_t cnt_o,
  output logic wrap_o
);
  cnt_t cnt_q;

  assign wrap_o = active_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (wrap_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + cnt_t'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hb_dead_cnt.sv
module hb_dead_cnt #(
  parameter int unsigned DT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_on_i,
  output logic ok_o
);
  localparam int unsigned DW = $clog2(DT_CYCLES + 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= DW'(DT_CYCLES);
    else if (any_on_i)                cnt_q <= '0;
    else if (cnt_q != DW'(DT_CYCLES)) cnt_q <= cnt_q + DW'(1);
  end

  // current cycle is the DT-th low one: a rise may be registered now
  assign ok_o = cnt_q >= DW'(DT_CYCLES - 1);
endmodule

// File: rtl/hb_out_stage.sv
module hb_out_stage
  import hb_pulse_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  cnt_t cnt_i,
  input  win_t win_i,
  input  logic dead_ok_i,
  output logic ho_o,
  output logic lo_o
);
  logic ho_q, lo_q;
  logic lo_want, ho_want, lo_d, ho_d;

  assign lo_want = cnt_i < win_i.lo_end;
  assign ho_want = (cnt_i >= win_i.ho_start) && (cnt_i < win_i.ho_end);

  // a rising edge needs the other side low and the dead gap served
  assign lo_d = active_i && lo_want && (lo_q || (dead_ok_i && !ho_q));
  assign ho_d = active_i && ho_want && (ho_q || (dead_ok_i && !lo_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ho_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      ho_q <= ho_d;
      lo_q <= lo_d;
    end
  end

  assign ho_o = ho_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/hb_pulse_gen.sv
module hb_pulse_gen
  import hb_pulse_pkg::*;
#(
  parameter int unsigned IGN_PERIOD = 60,
  parameter int unsigned RUN_PERIOD = 100,
  parameter int unsigned DT_CYCLES  = 4,
  parameter int unsigned DUTY_W     = 6,
  parameter int unsigned FLOOR_DIV  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              force_off_i,
  input  logic              period_sel_i,
  input  logic [DUTY_W-1:0] duty_code_i,
  output logic              ho_o,
  output logic              lo_o
);
  localparam int unsigned MAX_PERIOD = (RUN_PERIOD > IGN_PERIOD) ? RUN_PERIOD : IGN_PERIOD;
  localparam int unsigned HO_LIMIT   = MAX_PERIOD / 2 - DT_CYCLES;

  logic active, wrap, load, dead_ok;
  cnt_t cnt;
  win_t win;

  assign active = run_i && !force_off_i;
  assign load   = !active || wrap;

  hb_win_calc #(
    .IGN_PERIOD(IGN_PERIOD),
    .RUN_PERIOD(RUN_PERIOD),
    .DT_CYCLES (DT_CYCLES),
    .DUTY_W    (DUTY_W),
    .FLOOR_DIV (FLOOR_DIV)
  ) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .sel_i (period_sel_i),
    .code_i(duty_code_i),
    .win_o (win)
  );

  hb_ramp u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .last_i  (win.last),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  hb_dead_cnt #(.DT_CYCLES(DT_CYCLES)) u_dead (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .any_on_i(ho_o || lo_o),
    .ok_o    (dead_ok)
  );

  hb_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .cnt_i    (cnt),
    .win_i    (win),
    .dead_ok_i(dead_ok),
    .ho_o     (ho_o),
    .lo_o     (lo_o)
  );
endmodule

// File: rtl/hb_pulse_gen_chk.sv
module hb_pulse_gen_chk #(
  parameter int unsigned DT_CYCLES = 4,
  parameter int unsigned HO_LIMIT  = 46
) (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic force_off_i,
  input logic ho_o,
  input logic lo_o
);
  logic [7:0]  gap_q;
  logic [15:0] ho_len_q;
  logic        fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= 8'(DT_CYCLES);
      ho_len_q <= '0;
      fresh_q  <= 1'b1;
    end else begin
      if (ho_o || lo_o)                gap_q <= '0;
      else if (gap_q != 8'(DT_CYCLES)) gap_q <= gap_q + 8'd1;
      ho_len_q <= ho_o ? ho_len_q + 16'd1 : '0;
      if (!run_i || force_off_i) fresh_q <= 1'b1;
      else if (lo_o)             fresh_q <= 1'b0;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ho_o && lo_o));

  p_dead_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ho_o) || $rose(lo_o)) |-> (gap_q >= 8'(DT_CYCLES)));

  p_ho_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ho_o |-> (ho_len_q < 16'(HO_LIMIT)));

  p_lo_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ho_o |-> !fresh_q);

  p_force_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (!ho_o && !lo_o));

  p_run_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!ho_o && !lo_o));
endmodule

bind hb_pulse_gen hb_pulse_gen_chk #(
  .DT_CYCLES(DT_CYCLES),
  .HO_LIMIT (HO_LIMIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .force_off_i(force_off_i),
  .ho_o       (ho_o),
  .lo_o       (lo_o)
);

// File: tb/tb_hb_pulse_gen.sv
`timescale 1ns/1ps
module tb_hb_pulse_gen;
  localparam int IGN_P = 60;
  localparam int RUN_P = 100;
  localparam int DT    = 4;
  localparam int DW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic force_off = 1'b0;
  logic sel = 1'b0;
  logic [DW-1:0] code = '0;
  logic ho, lo;

  int checks = 0;
  int failures = 0;
  int overlap = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hb_pulse_gen #(
    .IGN_PERIOD(IGN_P), .RUN_PERIOD(RUN_P), .DT_CYCLES(DT), .DUTY_W(DW), .FLOOR_DIV(10)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .force_off_i(force_off),
    .period_sel_i(sel), .duty_code_i(code), .ho_o(ho), .lo_o(lo)
  );

  always @(negedge clk) if (ho && lo) overlap++;

  function automatic int per_of(bit s);
    return s ? RUN_P : IGN_P;
  endfunction

  function automatic int ho_min(bit s);
    return (per_of(s) + 9) / 10;
  endfunction

  function automatic int exp_ho(bit s, int c);
    int mx = per_of(s) / 2 - DT;
    return (c >= mx - ho_min(s)) ? ho_min(s) : mx - c;
  endfunction

  function automatic int exp_lo(bit s, int c);
    return per_of(s) - 2 * DT - exp_ho(s, c);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic measure(output int lw, output int g1, output int hw, output int g2);
    lw = 0; g1 = 0; hw = 0; g2 = 0;
    while (lo)        begin lw++; @(negedge clk); end
    while (!lo && !ho) begin g1++; @(negedge clk); end
    while (ho)        begin hw++; @(negedge clk); end
    while (!lo && !ho) begin g2++; @(negedge clk); end
  endtask

  // enters at the negedge where lo was first seen high; leaves at the next such one
  task automatic check_period(bit s, int c, string tag);
    int lw, g1, hw, g2;
    measure(lw, g1, hw, g2);
    chk((exp_ho(s, c) == ho_min(s)) ? "R5" : "R4", {tag, " ho width"}, hw, exp_ho(s, c));
    chk("R4", {tag, " lo width"}, lw, exp_lo(s, c));
    chk("R2", {tag, " gap lo->ho"}, g1, DT);
    chk("R2", {tag, " gap ho->lo"}, g2, DT);
    chk("R3", {tag, " period"}, lw + g1 + hw + g2, per_of(s));
  endtask

  task automatic skip_period();
    int lw, g1, hw, g2;
    measure(lw, g1, hw, g2);
  endtask

  task automatic first_rise_is_lo(string tag);
    while (!ho && !lo) @(negedge clk);
    chk("R6", {tag, " first rise is lo"}, int'(lo && !ho), 1);
  endtask

  task automatic stop_and_check(bit use_force, string tag);
    int bad = 0;
    if (use_force) force_off = 1'b1; else run = 1'b0;
    @(negedge clk);
    chk("R7", {tag, " both low next cycle"}, int'(ho || lo), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ho || lo) bad++;
    end
    chk("R7", {tag, " held low while stopped"}, bad, 0);
    force_off = 1'b0;
    run = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit s;
    int c;
    void'($urandom(32'd20240611));

    // R9: reset
    repeat (3) @(negedge clk);
    chk("R9", "ho in reset", int'(ho), 0);
    chk("R9", "lo in reset", int'(lo), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", "idle with run low", int'(ho || lo), 0);

    // R6: start in ignition mode
    sel = 1'b0; code = '0;
    run = 1'b1;
    first_rise_is_lo("start");
    check_period(1'b0, 0, "ign code0");

    // directed codes; each new setting applies after the current period
    sel = 1'b0; code = 6'd25; skip_period();
    check_period(1'b0, 25, "ign floor");
    sel = 1'b0; code = 6'd19; skip_period();
    check_period(1'b0, 19, "ign below clamp");
    sel = 1'b1; code = 6'd0; skip_period();
    check_period(1'b1, 0, "run code0");
    sel = 1'b1; code = 6'd35; skip_period();
    check_period(1'b1, 35, "run below clamp");
    sel = 1'b1; code = 6'd36; skip_period();
    check_period(1'b1, 36, "run at clamp");
    sel = 1'b1; code = 6'd63; skip_period();
    check_period(1'b1, 63, "run max code");

    // R8: change at a period start; that period keeps the old setting
    sel = 1'b1; code = 6'd0; skip_period();
    skip_period();
    sel = 1'b0; code = 6'd10;
    check_period(1'b1, 0, "R8 old setting kept");
    check_period(1'b0, 10, "R8 new setting");

    // R7/R6: force-off during ho, restart
    while (!ho) @(negedge clk);
    stop_and_check(1'b1, "force in ho");
    first_rise_is_lo("after force");
    check_period(1'b0, 10, "after force");

    // R7/R6: run low during lo, restart
    @(negedge clk);
    stop_and_check(1'b0, "run low in lo");
    first_rise_is_lo("after run low");
    check_period(1'b0, 10, "after run low");

    // random settings
    for (int i = 0; i < 12; i++) begin
      s = 1'($urandom % 2);
      c = int'($urandom % 64);
      sel = s; code = 6'(c);
      skip_period();
      check_period(s, c, "random");
    end

    chk("R1", "cycles with ho and lo both high", overlap, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule